// File: doc/BRIEF.md
# Bit-Order Configurable Serial Frame Shifter

This block moves one byte-wide frame over a serial data line, one bit for each single-cycle shift strobe, and receives a frame over the same strobes at the same time. A mode register picks the transfer order (most significant bit first or least significant bit first) and a frame length of 1 to 8 data bits. When a frame is shorter than 8 bits, the order bit also decides which end of the byte holds the frame. Transmit bits are taken from the end that is sent first. Received bits collect at the end away from where the shift starts.

The host writes the mode register and a transmit holding register, then pulses `start`. After the configured number of data strobes, the block pulses `done` and loads the receive register. It then waits in an acknowledge slot for one more strobe. That strobe samples the acknowledge bit and is not counted as data. Clock generation, bus conditions, address matching and line drivers sit outside the block.

Top module: `frame_shifter`

## Requirements
- R1: After reset the mode register reads 0x00 (with `if_en` high), `busy`, `done` and `ack_slot` are 0, and `sda_out` is 1.
- R2: The mode register takes writes only while `if_en` is 1. While `if_en` is 0, writes are ignored and `mode_rdata` reads 0x00. Bit 7 is the order bit (0 = MSB-first, 1 = LSB-first), and bits 2:0 are the length field.
- R3: Length field value 0 selects 8 data bits, and values 1 to 7 select that many. `busy` is high from the cycle after `start` until the acknowledge strobe, which comes after exactly that many data strobes.
- R4: With order 0, data bit k (counting from 0) on `sda_out` is transmit bit 7-k, so a short frame uses the top bits of the byte.
- R5: With order 1, data bit k on `sda_out` is transmit bit k, so a short frame uses the bottom bits of the byte.
- R6: With order 0 and N data bits, the k-th bit sampled from `sda_in` lands in `rx_rdata` bit N-1-k, so the frame sits at the LSB end.
- R7: With order 1 and N data bits, the k-th bit sampled lands in `rx_rdata` bit 8-N+k, so the frame sits at the MSB end.
- R8: `done` is high for exactly one cycle, the cycle after the clock edge that takes the last data strobe. `rx_rdata` is updated at that same edge. `ack_slot` is high from that cycle until the acknowledge strobe.
- R9: During the acknowledge slot `sda_out` is 1. The acknowledge strobe copies `sda_in` to `ack_seen` and ends the frame.
- R10: A transmit write or a mode write during a frame does not change the bits or the length of that frame. It takes effect from the next `start`.
- R11: `start` while busy is ignored. A strobe while idle has no effect: `sda_out` stays 1 and `busy` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| if_en | input | 1 | Interface enable; gates mode register access |
| mode_wr | input | 1 | Mode register write strobe |
| mode_wdata | input | 8 | Mode register write data |
| mode_rdata | output | 8 | Mode register read data (zero while disabled) |
| tx_wr | input | 1 | Transmit holding register write strobe |
| tx_wdata | input | 8 | Transmit byte |
| rx_rdata | output | 8 | Last received frame |
| start | input | 1 | Begin a frame (ignored while busy) |
| shift_stb | input | 1 | One-cycle bit strobe |
| sda_in | input | 1 | Serial data sampled on each strobe |
| sda_out | output | 1 | Serial data presented; 1 when not in a data bit |
| busy | output | 1 | Frame in progress |
| ack_slot | output | 1 | Waiting for the acknowledge strobe |
| done | output | 1 | One-cycle pulse after the last data bit |
| ack_seen | output | 1 | Acknowledge bit sampled on the last frame |

## Verification
The hardest case to reach is a host write that lands in the middle of a frame. It has to arrive between two strobes, after part of the byte has left, and together with a redundant `start`. The bench does this inside an 8-bit frame after three strobes. It writes a new byte and a new mode at that point, checks that the rest of the old byte still comes out in the old order, and then starts a frame with no setup to show that the new byte, order and length apply only from then on. All other cases are covered by a sweep over both orders, all eight length codes and several bit patterns, with expected line bits and justified receive bytes worked out arithmetically.

// File: rtl/fs_pkg.sv
package fs_pkg;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_DATA = 2'd1,
    FS_ACK  = 2'd2
  } fs_state_e;

  // Length field to data bit count: zero encodes a full word.
  function automatic int unsigned fs_len(input int unsigned field, input int unsigned word_w);
    return (field == 0) ? word_w : field;
  endfunction

endpackage

// File: rtl/fs_mode_reg.sv
module fs_mode_reg #(
  parameter int MODE_W    = 8,
  parameter int ORDER_BIT = 7,
  parameter int CNT_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              if_en,
  input  logic              wr,
  input  logic [MODE_W-1:0] wdata,
  output logic [MODE_W-1:0] rdata,
  output logic              order_lsb,
  output logic [CNT_W-1:0]  len_field
);

  logic [MODE_W-1:0] mode_q;
  logic              wr_accept;

  assign wr_accept = wr & if_en;

  always_ff @(posedge clk) begin
    if (!rst_n)         mode_q <= '0;
    else if (wr_accept) mode_q <= wdata;
  end

  assign rdata     = if_en ? mode_q : '0;
  assign order_lsb = mode_q[ORDER_BIT];
  assign len_field = mode_q[CNT_W-1:0];

  AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !if_en) |=> $stable(mode_q)); // R2

endmodule

// File: rtl/fs_ctrl.sv
module fs_ctrl #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                shift_stb,
  input  logic [CNT_W-1:0]    len_field,
  output fs_pkg::fs_state_e   state,
  output logic                load_evt,
  output logic                shift_evt,
  output logic                last_evt,
  output logic                ack_evt,
  output logic                done
);
  import fs_pkg::*;

  localparam int LEN_W = CNT_W + 1;

  fs_state_e  state_q;
  logic [LEN_W-1:0] bits_left;

  assign load_evt  = (state_q == FS_IDLE) && start;
  assign shift_evt = (state_q == FS_DATA) && shift_stb;
  assign last_evt  = shift_evt && (bits_left == LEN_W'(1));
  assign ack_evt   = (state_q == FS_ACK) && shift_stb;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= FS_IDLE;
      bits_left <= '0;
      done      <= 1'b0;
    end else begin
      done <= last_evt;
      unique case (state_q)
        FS_IDLE: if (load_evt) begin
          state_q   <= FS_DATA;
          bits_left <= LEN_W'(fs_len(32'(len_field), 32'(DATA_W)));
        end
        FS_DATA: if (shift_evt) begin
          bits_left <= bits_left - LEN_W'(1);
          if (last_evt) state_q <= FS_ACK;
        end
        FS_ACK: if (ack_evt) state_q <= FS_IDLE;
        default: state_q <= FS_IDLE;
      endcase
    end
  end

  assign state = state_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_IN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (state_q == FS_ACK)); // R8
  AST_LEFT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == FS_DATA) |-> (bits_left >= LEN_W'(1) && bits_left <= LEN_W'(DATA_W))); // R3
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == FS_DATA) && start && !shift_stb) |=> ($stable(bits_left) && state_q == FS_DATA)); // R11

endmodule

// File: rtl/fs_shifter.sv
module fs_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic              last,
  input  logic              ack,
  input  logic              data_phase,
  input  logic              order_lsb,
  input  logic [DATA_W-1:0] tx_word,
  input  logic              sda_in,
  output logic              sda_out,
  output logic [DATA_W-1:0] rx_word,
  output logic              ack_bit
);

  // One shift step: the line bit leaves at the sending end, the sampled bit
  // enters at the opposite end, so short frames justify themselves.
  function automatic logic [DATA_W-1:0] step(input logic [DATA_W-1:0] s,
                                             input logic b, input logic lsb);
    return lsb ? {b, s[DATA_W-1:1]} : {s[DATA_W-2:0], b};
  endfunction

  logic [DATA_W-1:0] sh_q;
  logic [DATA_W-1:0] sh_next;
  logic              lsb_q;

  assign sh_next = step(sh_q, sda_in, lsb_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q    <= '0;
      lsb_q   <= 1'b0;
      rx_word <= '0;
      ack_bit <= 1'b0;
    end else begin
      if (load) begin
        sh_q  <= tx_word;
        lsb_q <= order_lsb;
      end else if (shift) begin
        sh_q <= sh_next;
      end
      if (last) rx_word <= sh_next;
      if (ack)  ack_bit <= sda_in;
    end
  end

  assign sda_out = data_phase ? (lsb_q ? sh_q[0] : sh_q[DATA_W-1]) : 1'b1;

  AST_SH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !shift) |=> $stable(sh_q)); // R10
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !last |=> $stable(rx_word)); // R8
  AST_IDLE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    !data_phase |-> sda_out); // R9

endmodule

// File: rtl/frame_shifter.sv
module frame_shifter #(
  parameter int DATA_W    = 8,
  parameter int MODE_W    = 8,
  parameter int ORDER_BIT = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              if_en,
  input  logic              mode_wr,
  input  logic [MODE_W-1:0] mode_wdata,
  output logic [MODE_W-1:0] mode_rdata,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_wdata,
  output logic [DATA_W-1:0] rx_rdata,
  input  logic              start,
  input  logic              shift_stb,
  input  logic              sda_in,
  output logic              sda_out,
  output logic              busy,
  output logic              ack_slot,
  output logic              done,
  output logic              ack_seen
);
  import fs_pkg::*;

  localparam int CNT_W = $clog2(DATA_W);

  logic              order_lsb;
  logic [CNT_W-1:0]  len_field;
  logic [DATA_W-1:0] tx_q;
  fs_state_e         state;
  logic              load_evt, shift_evt, last_evt, ack_evt;

  fs_mode_reg #(.MODE_W(MODE_W), .ORDER_BIT(ORDER_BIT), .CNT_W(CNT_W)) u_mode (
    .clk(clk), .rst_n(rst_n), .if_en(if_en), .wr(mode_wr), .wdata(mode_wdata),
    .rdata(mode_rdata), .order_lsb(order_lsb), .len_field(len_field)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)     tx_q <= '0;
    else if (tx_wr) tx_q <= tx_wdata;
  end

  fs_ctrl #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .shift_stb(shift_stb),
    .len_field(len_field), .state(state), .load_evt(load_evt),
    .shift_evt(shift_evt), .last_evt(last_evt), .ack_evt(ack_evt), .done(done)
  );

  fs_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load_evt), .shift(shift_evt),
    .last(last_evt), .ack(ack_evt), .data_phase(state == FS_DATA),
    .order_lsb(order_lsb), .tx_word(tx_q), .sda_in(sda_in),
    .sda_out(sda_out), .rx_word(rx_rdata), .ack_bit(ack_seen)
  );

  assign busy     = (state != FS_IDLE);
  assign ack_slot = (state == FS_ACK);

  AST_ACK_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_slot && shift_stb) |=> !busy); // R9
  AST_IDLE_STB: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !busy); // R11

endmodule

// File: tb/tb_frame_shifter.sv
`timescale 1ns/1ps
module tb_frame_shifter;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       if_en = 1'b1;
  logic       mode_wr = 1'b0;
  logic [7:0] mode_wdata = '0;
  logic [7:0] mode_rdata;
  logic       tx_wr = 1'b0;
  logic [7:0] tx_wdata = '0;
  logic [7:0] rx_rdata;
  logic       start = 1'b0;
  logic       shift_stb = 1'b0;
  logic       sda_in = 1'b0;
  logic       sda_out, busy, ack_slot, done, ack_seen;

  int nchk = 0;
  int nerr = 0;

  always #2.5 clk = ~clk;

  frame_shifter dut (
    .clk(clk), .rst_n(rst_n), .if_en(if_en), .mode_wr(mode_wr),
    .mode_wdata(mode_wdata), .mode_rdata(mode_rdata), .tx_wr(tx_wr),
    .tx_wdata(tx_wdata), .rx_rdata(rx_rdata), .start(start),
    .shift_stb(shift_stb), .sda_in(sda_in), .sda_out(sda_out), .busy(busy),
    .ack_slot(ack_slot), .done(done), .ack_seen(ack_seen)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_mode(input logic [7:0] v, input logic en);
    @(negedge clk); if_en = en; mode_wr = 1'b1; mode_wdata = v;
    @(negedge clk); mode_wr = 1'b0; if_en = 1'b1;
  endtask

  task automatic write_tx(input logic [7:0] v);
    @(negedge clk); tx_wr = 1'b1; tx_wdata = v;
    @(negedge clk); tx_wr = 1'b0;
  endtask

  // One frame; expected line bits and receive byte computed arithmetically.
  task automatic run_frame(input logic order, input int cnt, input logic [7:0] tx,
                           input logic [7:0] rxpat, input logic ackb,
                           input bit setup, input bit disturb);
    int n;
    logic [7:0] exp_rx, mask;
    n = (cnt == 0) ? 8 : cnt;
    if (setup) begin
      write_mode({order, 4'b0000, cnt[2:0]}, 1'b1);
      write_tx(tx);
    end
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R3 busy after start", {31'b0, busy}, 32'd1);
    exp_rx = '0;
    for (int k = 0; k < n; k++) begin
      if (disturb && k == 3) begin
        tx_wr = 1'b1; tx_wdata = 8'h3C; mode_wr = 1'b1; mode_wdata = 8'h82; start = 1'b1;
        @(negedge clk);
        tx_wr = 1'b0; mode_wr = 1'b0; start = 1'b0;
        chk("R11 start while busy", {31'b0, busy}, 32'd1);
      end
      if (order) chk("R5 lsb-first line bit", {31'b0, sda_out}, {31'b0, tx[k]});
      else       chk("R4 msb-first line bit", {31'b0, sda_out}, {31'b0, tx[7-k]});
      chk("R8 no early done", {31'b0, done}, 32'd0);
      sda_in = rxpat[k];
      if (order) exp_rx[8-n+k] = rxpat[k];
      else       exp_rx[n-1-k] = rxpat[k];
      shift_stb = 1'b1;
      @(negedge clk); shift_stb = 1'b0;
    end
    mask = order ? 8'(8'hFF << (8-n)) : 8'(8'hFF >> (8-n));
    chk("R8 done pulse", {31'b0, done}, 32'd1);
    chk("R8 ack slot", {31'b0, ack_slot}, 32'd1);
    chk("R9 line released", {31'b0, sda_out}, 32'd1);
    if (order) chk("R7 rx msb-justified", {24'b0, rx_rdata & mask}, {24'b0, exp_rx});
    else       chk("R6 rx lsb-justified", {24'b0, rx_rdata & mask}, {24'b0, exp_rx});
    @(negedge clk);
    chk("R8 done one cycle", {31'b0, done}, 32'd0);
    chk("R3 ack not data", {31'b0, busy & ack_slot}, 32'd1);
    sda_in = ackb; shift_stb = 1'b1;
    @(negedge clk); shift_stb = 1'b0;
    chk("R3 frame ends", {31'b0, busy}, 32'd0);
    chk("R9 ack sampled", {31'b0, ack_seen}, {31'b0, ackb});
  endtask

  initial begin
    #(200000 * 5);
    nerr++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk + 1);
    $finish;
  end

  initial begin
    logic [7:0] pats [3];
    pats[0] = 8'hA5; pats[1] = 8'h3C; pats[2] = 8'hD2;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1 mode reset", {24'b0, mode_rdata}, 32'd0);
    chk("R1 busy reset", {31'b0, busy}, 32'd0);
    chk("R1 done reset", {31'b0, done}, 32'd0);
    chk("R1 ack slot reset", {31'b0, ack_slot}, 32'd0);
    chk("R1 line reset", {31'b0, sda_out}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    // R2: access gating
    write_mode(8'h85, 1'b1);
    chk("R2 mode readback", {24'b0, mode_rdata}, 32'h85);
    write_mode(8'h03, 1'b0);
    if_en = 1'b0; #0.1;
    chk("R2 disabled read zero", {24'b0, mode_rdata}, 32'd0);
    if_en = 1'b1; #0.1;
    chk("R2 disabled write ignored", {24'b0, mode_rdata}, 32'h85);
    // R11: strobe while idle
    @(negedge clk); shift_stb = 1'b1;
    @(negedge clk); shift_stb = 1'b0;
    chk("R11 idle strobe line", {31'b0, sda_out}, 32'd1);
    chk("R11 idle strobe busy", {31'b0, busy}, 32'd0);
    // Sweep: both orders, every length code, several patterns (R3-R9)
    for (int o = 0; o < 2; o++)
      for (int c = 0; c < 8; c++)
        for (int p = 0; p < 3; p++)
          run_frame(o[0], c, pats[p], ~pats[(p + 1) % 3], p[0], 1'b1, 1'b0);
    // R10: mid-frame writes, then a frame using only the new settings
    run_frame(1'b0, 0, 8'hA5, 8'h69, 1'b1, 1'b1, 1'b1);
    chk("R10 mode updated after frame", {24'b0, mode_rdata}, 32'h82);
    run_frame(1'b1, 2, 8'h3C, 8'h02, 1'b0, 1'b0, 1'b0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule